// File: doc/BRIEF.md
# Interleaved Multichannel FIR Filter

This block runs the FIR filtering for a group of slow ADC channels on one datapath clocked far faster than any single channel's sample rate. Samples arrive one per cycle at most, each tagged with its channel number. The channel number selects two things: the coefficients to apply and the stored history of past samples for that channel. The filtered result leaves with the same tag, in the same order as the inputs.

Each channel keeps its own coefficient set, so one instance can give different channels different filter shapes. Software-side logic loads coefficients through a write port addressed by channel and tap. That port takes effect only while the filter has no sample in flight or is held in reset. With the defaults, one instance serves 64 channels with 16 taps, 12-bit signed samples and 16-bit signed coefficients. The clock ratio leaves 100 processing cycles per channel sample period.

Top module: `mcfir`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `out_valid` is low. Reset clears every channel's history to zero. It leaves the stored coefficients unchanged.
- R2: For an accepted sample x[n] on channel ch, the block forms acc = sum over k of c[ch][k] * x[n-k] at full precision. Tap index k = 0 multiplies the newest sample, and k = NTAP-1 multiplies the sample NTAP-1 periods older.
- R3: Each channel's history advances only when a sample for that channel is accepted. Samples for other channels, and idle cycles between samples, leave it unchanged.
- R4: A sample accepted at clock edge k produces `out_valid` high exactly 3 edges later. `out_ch` equals the input's channel at that point. No output appears without a matching input, so outputs keep input order.
- R5: The output is acc rounded half toward positive infinity and scaled down by 2^SHIFT (SHIFT = 11): floor((acc + 1024) / 2048).
- R6: A rounded value above 32767 is emitted as 32767, and one below -32768 is emitted as -32768.
- R7: A coefficient write takes effect when `rst` is high, or when `in_valid` is low and neither of the two internal pipeline stages holds a sample. In every other cycle the write is dropped.
- R8: After reset, each channel's first NTAP-1 outputs are computed as if every earlier sample had been zero.
- R9: A write with `cfg_we` high stores the signed value `cfg_data` as coefficient c[`cfg_ch`][`cfg_tap`], with tap numbering as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_ch | input | 6 | Channel of the input sample |
| in_data | input | 12 | Signed input sample |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_ch | input | 6 | Channel of the coefficient being written |
| cfg_tap | input | 4 | Tap index of the coefficient being written |
| cfg_data | input | 16 | Signed coefficient value |
| out_valid | output | 1 | Filtered sample present this cycle |
| out_ch | output | 6 | Channel of the filtered sample |
| out_data | output | 16 | Signed, rounded, saturated filter output |

## Verification
The bench targets the places where interleaving usually goes wrong. If one channel's history were leaked or shifted on another channel's sample, or on an idle cycle, the outputs would drift away from a per-channel model. If the tap order were reversed, asymmetric coefficient sets would give the wrong output. Rounding is probed at exact half-way sums, where an offset of one LSB or rounding toward zero shows up at once. Sums driven far past full scale expose wrap-around where saturation was needed. Coefficient writes are attempted in the same cycle as an input and while samples are still in the pipeline. A design that accepted them would change later outputs on the affected channel.

// File: rtl/mcfir.sv
module mcfir #(
  parameter int NCH   = 64,
  parameter int NTAP  = 16,
  parameter int XW    = 12,
  parameter int CW    = 16,
  parameter int OW    = 16,
  parameter int SHIFT = 11
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [$clog2(NCH)-1:0] in_ch,
  input  logic signed [XW-1:0]   in_data,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [$clog2(NTAP)-1:0] cfg_tap,
  input  logic signed [CW-1:0]   cfg_data,
  output logic                   out_valid,
  output logic [$clog2(NCH)-1:0] out_ch,
  output logic signed [OW-1:0]   out_data
);
  localparam int CHW = $clog2(NCH);
  localparam int PW  = XW + CW;
  localparam int AW  = PW + $clog2(NTAP) + 2;
  localparam int HW  = (NTAP - 1) * XW;
  localparam logic signed [AW-1:0] OMAX = AW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [AW-1:0] OMIN = -AW'(1 <<< (OW - 1));
  localparam logic signed [AW-1:0] HALF = AW'(1 <<< (SHIFT - 1));

  logic [HW-1:0]         hist [NCH];
  logic signed [CW-1:0]  coef [NCH][NTAP];

  logic                  va, vb;
  logic [CHW-1:0]        cha, chb;
  logic signed [XW-1:0]  wa [NTAP];
  logic signed [CW-1:0]  ca [NTAP];
  logic signed [PW-1:0]  prod [NTAP];

  logic [NTAP*XW-1:0]    win;
  logic                  busy;
  logic signed [AW-1:0]  acc, rnd, scl;

  assign win  = {hist[in_ch], in_data};
  assign busy = in_valid | va | vb;

  always_ff @(posedge clk) begin
    if (cfg_we && (rst || !busy))
      coef[cfg_ch][cfg_tap] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) hist[c] <= '0;
    end else if (in_valid) begin
      hist[in_ch] <= win[HW-1:0];
    end
  end

  generate
    for (genvar k = 0; k < NTAP; k++) begin : g_tap
      always_ff @(posedge clk) begin
        if (in_valid) begin
          wa[k] <= win[k*XW +: XW];
          ca[k] <= coef[in_ch][k];
        end
        if (va) prod[k] <= wa[k] * ca[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      va <= 1'b0;
      vb <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      va <= in_valid;
      vb <= va;
      out_valid <= vb;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) cha <= in_ch;
    if (va) chb <= cha;
    if (vb) begin
      out_ch <= chb;
      if (scl > OMAX)      out_data <= OMAX[OW-1:0];
      else if (scl < OMIN) out_data <= OMIN[OW-1:0];
      else                 out_data <= scl[OW-1:0];
    end
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NTAP; k++) acc = acc + AW'(prod[k]);
  end

  assign rnd = acc + HALF;
  assign scl = rnd >>> SHIFT;

endmodule

// File: rtl/mcfir_chk.sv
module mcfir_chk #(
  parameter int CHW = 6
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [CHW-1:0] in_ch,
  input logic           out_valid,
  input logic [CHW-1:0] out_ch
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 out_valid);

  assert_tag_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##3 (out_ch == $past(in_ch, 3)));

  assert_no_orphan_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 3));
endmodule

bind mcfir mcfir_chk #(.CHW($clog2(NCH))) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ch(in_ch),
  .out_valid(out_valid), .out_ch(out_ch)
);

// File: tb/sim_mcfir.sv
module sim_mcfir;
  localparam int NCH = 64, NTAP = 16, XW = 12, CW = 16, OW = 16, SHIFT = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [5:0] in_ch = '0;
  logic signed [XW-1:0] in_data = '0;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_ch = '0;
  logic [3:0] cfg_tap = '0;
  logic signed [CW-1:0] cfg_data = '0;
  logic out_valid;
  logic [5:0] out_ch;
  logic signed [OW-1:0] out_data;

  always #5 clk = ~clk;

  mcfir u0 (.*);

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0, reported = 0;

  int mh [NCH][NTAP];
  int mc [NCH][NTAP];
  int pv [3], pc [3], pd [3];
  bit hard_on = 0;
  int hq [$];

  function automatic int expect_out(int ch);
    longint acc = 0, r;
    for (int k = 0; k < NTAP; k++) acc += longint'(mh[ch][k]) * longint'(mc[ch][k]);
    r = (acc + 1024) >>> SHIFT;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  always @(posedge clk) begin
    bit mbusy;
    mbusy = in_valid || pv[0] != 0 || pv[1] != 0;
    if (cfg_we && (rst || !mbusy)) mc[cfg_ch][cfg_tap] = int'(cfg_data);
    if (rst) begin
      for (int c = 0; c < NCH; c++) for (int k = 0; k < NTAP; k++) mh[c][k] = 0;
      for (int s = 0; s < 3; s++) pv[s] = 0;
    end else begin
      pv[2] = pv[1]; pc[2] = pc[1]; pd[2] = pd[1];
      pv[1] = pv[0]; pc[1] = pc[0]; pd[1] = pd[0];
      pv[0] = int'(in_valid);
      if (in_valid) begin
        for (int k = NTAP - 1; k > 0; k--) mh[in_ch][k] = mh[in_ch][k-1];
        mh[in_ch][0] = int'(in_data);
        pc[0] = int'(in_ch);
        pd[0] = expect_out(int'(in_ch));
      end
    end
  end

  always @(negedge clk) begin
    if (!reported) begin
      checks++;
      if (int'(out_valid) != pv[2]) begin
        fails++;
        $display("FAIL R4 (%s): out_valid got %0d expected %0d", tag, out_valid, pv[2]);
      end
      if (out_valid && pv[2] != 0) begin
        checks++;
        if (int'(out_ch) != pc[2]) begin
          fails++;
          $display("FAIL R4: out_ch got %0d expected %0d", out_ch, pc[2]);
        end
        checks++;
        if (int'(out_data) != pd[2]) begin
          fails++;
          $display("FAIL %s: ch %0d out_data got %0d expected %0d", tag, out_ch, out_data, pd[2]);
        end
        if (hard_on && hq.size() > 0) begin
          int e;
          e = hq.pop_front();
          checks++;
          if (int'(out_data) != e) begin
            fails++;
            $display("FAIL R5: half-way rounding got %0d expected %0d", out_data, e);
          end
        end
      end
    end
  end

  task automatic wr(input int ch, input int tap, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 6'(ch); cfg_tap = 4'(tap); cfg_data = CW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input int ch, input int x);
    @(negedge clk);
    in_valid = 1'b1; in_ch = 6'(ch); in_data = XW'(x);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n - 1) @(negedge clk);
  endtask

  function automatic int rnd_x();
    return int'($urandom_range(4094)) - 2047;
  endfunction

  task automatic frames(input int n, input bit gaps);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < NCH; c++) begin
        send(c, rnd_x());
        if (gaps && ($urandom_range(3) == 0)) idle(1 + int'($urandom_range(2)));
      end
  endtask

  initial begin
    tag = "R1";
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < NTAP; k++) begin
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 6'(c); cfg_tap = 4'(k);
        cfg_data = CW'((((c * 37 + k * 53) % 401) - 200) * 80);
      end
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    tag = "R8";
    frames(NTAP - 1, 1'b0);
    tag = "R2";
    frames(10, 1'b0);
    tag = "R3";
    frames(8, 1'b1);
    idle(5);

    tag = "R7";
    send(5, 100);
    cfg_we = 1'b1; cfg_ch = 6'd5; cfg_tap = 4'd0; cfg_data = 16'sd32767;
    @(negedge clk);
    in_valid = 1'b0;
    cfg_ch = 6'd6; cfg_tap = 4'd0; cfg_data = -16'sd32768;
    @(negedge clk);
    cfg_ch = 6'd7; cfg_tap = 4'd1; cfg_data = 16'sd32767;
    @(negedge clk);
    cfg_we = 1'b0;
    idle(4);
    frames(3, 1'b0);
    idle(5);

    tag = "R9";
    wr(2, 7, 20000);
    wr(2, 0, -3);
    for (int k = 0; k < NTAP; k++) wr(0, k, (k == 0) ? 1 : 0);
    frames(3, 1'b1);
    idle(5);

    tag = "R5";
    hard_on = 1'b1;
    hq.push_back(1); hq.push_back(0); hq.push_back(0); hq.push_back(-1);
    send(0, 1024); send(0, 1023); send(0, -1024); send(0, -1025);
    idle(6);
    hard_on = 1'b0;

    tag = "R6";
    for (int k = 0; k < NTAP; k++) wr(1, k, 32767);
    for (int k = 0; k < NTAP; k++) wr(3, k, -32768);
    for (int i = 0; i < NTAP + 2; i++) begin
      send(1, 2047);
      send(3, 2047);
    end
    for (int i = 0; i < NTAP + 2; i++) begin
      send(1, -2048);
      send(3, -2048);
    end
    idle(6);

    tag = "R1";
    rst = 1'b1;
    send(4, 500);
    idle(3);
    rst = 1'b0;
    tag = "R8";
    frames(2, 1'b0);
    idle(6);

    done = 1'b1;
    reported = 1'b1;
    if (hq.size() != 0) begin
      fails++;
      $display("FAIL R5: %0d rounding results never appeared, expected 0", hq.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done && !reported) begin
      reported = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule